// File: doc/BRIEF.md
# Stereo Serial Audio Receiver with Magnitude Output

This block sits behind a stereo I2S input whose bit clock runs at 64 times the sample rate. That bit clock is the only clock the block uses. The block follows the word-select line to learn which channel is being sent. It shifts in the first 16 data bits of each 32-bit half-frame and turns each two's-complement sample into its absolute magnitude. Samples are taken on the rising edge of the bit clock, and the sending side is expected to change word select and data on the falling edge.

Both channels' magnitudes leave on one shared 16-bit bus. Each channel has its own strobe, so two mono level meters can hang off the same bus: each meter loads the word only when its own strobe is high. The output side is a push-only stream. There is no ready input and no back-pressure, because the serial source cannot be paused. A strobe is a one-cycle offer that the consumer must take in that cycle. The bus word then stays unchanged until the next strobe, so a slower consumer may also read it at any later point before that.

Top module: `i2s_mag_rx`

## Requirements
- R1: While reset is asserted (`rst_n` low), and on the first cycle after it, `mag_o` is 0 and both `left_vld` and `right_vld` are low. Every register changes only on the rising edge of `sclk`.
- R2: A half-frame sent with `ws` at 0 is reported on `left_vld`. A half-frame sent with `ws` at 1 is reported on `right_vld`.
- R3: The sample is the 16 bits sampled on rising edges 1 to 16 after the edge that first sees the new `ws` level, taken MSB first. Edge 1 is therefore the second rising edge after the word-select change. Data bits after the 16th in the half-frame have no effect on the reported value.
- R4: The reported value is the absolute value of the 16-bit two's-complement sample. Bit 15 of `mag_o` is 0 on every strobe.
- R5: The sample 0x8000 (−32768) is reported as 0x7FFF.
- R6: A channel strobe is high for exactly one cycle, in the cycle after rising edge 17 counted from the `ws`-change edge. `mag_o` holds the new value from that cycle and stays unchanged until the next strobe.
- R7: `left_vld` and `right_vld` are never high in the same cycle.
- R8: After reset, no strobe is issued until a `ws` transition has been seen. Bits of a half-frame that was already in progress when reset was released are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock at 64 times the sample rate; the only clock of the block |
| rst_n | input | 1 | Active-low reset, synchronous to `sclk` |
| ws | input | 1 | Word select: 0 means left channel, 1 means right channel |
| sd | input | 1 | Serial audio data, MSB first |
| mag_o | output | 16 | Rectified sample magnitude, shared by both channels |
| left_vld | output | 1 | One-cycle strobe: `mag_o` holds a new left magnitude |
| right_vld | output | 1 | One-cycle strobe: `mag_o` holds a new right magnitude |

## Verification
The embedded assertions check four properties on every cycle:
- the two strobes are mutually exclusive and each lasts a single cycle;
- bit 15 of the bus is clear whenever a strobe is high, and the bus holds between strobes;
- −32768 saturates to 0x7FFF;
- the capture counter is idle after a word is complete, and no strobe appears before the first word-select transition.

Other behaviours can only be shown by the bench's scenarios, which compare against a scoreboard of expected values:
- the channel mapping and the exact strobe cycle relative to the word-select change;
- MSB-first bit ordering and that trailing bits are ignored;
- that a half-frame already in progress at reset release is dropped.

// File: rtl/i2s_mag_pkg.sv
package i2s_mag_pkg;
  // Channel encoding follows the level of the word-select line.
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  localparam int unsigned SAMPLE_W_DEF = 16;
endpackage

// File: rtl/i2s_ws_track.sv
module i2s_ws_track
  import i2s_mag_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ws,
  output logic  start_o,
  output chan_e chan_o,
  output logic  seen_o
);
  logic ws_q;
  logic primed;

  // The first edge after reset only loads the history register,
  // so the initial level of ws is never mistaken for a transition.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_q   <= 1'b0;
      primed <= 1'b0;
      seen_o <= 1'b0;
    end else begin
      ws_q   <= ws;
      primed <= 1'b1;
      if (start_o) seen_o <= 1'b1;
    end
  end

  assign start_o = primed && (ws != ws_q);
  assign chan_o  = chan_e'(ws);
endmodule

// File: rtl/i2s_word_capture.sv
module i2s_word_capture
  import i2s_mag_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sd,
  input  logic                start_i,
  input  chan_e               chan_i,
  output logic [SAMPLE_W-1:0] word_o,
  output logic                done_o,
  output chan_e               chan_o
);
  localparam int unsigned CW = $clog2(SAMPLE_W + 1);
  localparam logic [CW-1:0] IDLE = CW'(SAMPLE_W);
  localparam logic [CW-1:0] LAST = CW'(SAMPLE_W - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= IDLE;
      word_o <= '0;
      done_o <= 1'b0;
      chan_o <= CH_LEFT;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        // The bit on the transition edge belongs to the previous slot.
        cnt    <= '0;
        chan_o <= chan_i;
      end else if (cnt != IDLE) begin
        word_o <= {word_o[SAMPLE_W-2:0], sd};
        cnt    <= cnt + 1'b1;
        if (cnt == LAST) done_o <= 1'b1;
      end
    end
  end

  // R6: completion pulses once per word.
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3: once a word is complete, no further bits are shifted in.
  p_idle_after_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> $stable(word_o));
endmodule

// File: rtl/i2s_mag_rectify.sv
module i2s_mag_rectify
  import i2s_mag_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] word_i,
  input  logic                load_i,
  input  chan_e               chan_i,
  output logic [SAMPLE_W-1:0] mag_o,
  output logic                left_vld,
  output logic                right_vld
);
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [SAMPLE_W-1:0] MOST_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};

  logic [SAMPLE_W-1:0] abs_val;

  always_comb begin
    if (word_i == MOST_NEG)    abs_val = MOST_POS;
    else if (word_i[SAMPLE_W-1]) abs_val = -word_i;
    else                         abs_val = word_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mag_o     <= '0;
      left_vld  <= 1'b0;
      right_vld <= 1'b0;
    end else begin
      left_vld  <= load_i && (chan_i == CH_LEFT);
      right_vld <= load_i && (chan_i == CH_RIGHT);
      if (load_i) mag_o <= abs_val;
    end
  end

  // R4: a reported magnitude never has its sign bit set.
  p_sign_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (left_vld || right_vld) |-> !mag_o[SAMPLE_W-1]);

  // R5: the most negative sample saturates.
  p_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && word_i == MOST_NEG) |=> (mag_o == MOST_POS));

  // R7: the two strobes are exclusive.
  p_excl_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({left_vld, right_vld}));

  // R6: each strobe lasts a single cycle.
  p_left_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    left_vld |=> !left_vld);
  p_right_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    right_vld |=> !right_vld);

  // R6: the bus only changes alongside a strobe.
  p_bus_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(left_vld || right_vld) |-> $stable(mag_o));
endmodule

// File: rtl/i2s_mag_rx.sv
module i2s_mag_rx
  import i2s_mag_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF
) (
  input  logic                sclk,
  input  logic                rst_n,
  input  logic                ws,
  input  logic                sd,
  output logic [SAMPLE_W-1:0] mag_o,
  output logic                left_vld,
  output logic                right_vld
);
  logic                start;
  logic                seen;
  chan_e               ws_chan;
  chan_e               word_chan;
  logic [SAMPLE_W-1:0] word;
  logic                word_done;

  i2s_ws_track u_track (
    .clk     (sclk),
    .rst_n   (rst_n),
    .ws      (ws),
    .start_o (start),
    .chan_o  (ws_chan),
    .seen_o  (seen)
  );

  i2s_word_capture #(.SAMPLE_W(SAMPLE_W)) u_capture (
    .clk     (sclk),
    .rst_n   (rst_n),
    .sd      (sd),
    .start_i (start),
    .chan_i  (ws_chan),
    .word_o  (word),
    .done_o  (word_done),
    .chan_o  (word_chan)
  );

  i2s_mag_rectify #(.SAMPLE_W(SAMPLE_W)) u_rectify (
    .clk       (sclk),
    .rst_n     (rst_n),
    .word_i    (word),
    .load_i    (word_done),
    .chan_i    (word_chan),
    .mag_o     (mag_o),
    .left_vld  (left_vld),
    .right_vld (right_vld)
  );

  // R8: nothing is reported before a word-select transition has been seen.
  p_no_early_strobe_r8: assert property (@(posedge sclk) disable iff (!rst_n)
    (left_vld || right_vld) |-> seen);
endmodule

// File: tb/i2s_mag_rx_test.sv
`timescale 1ns/1ps
module i2s_mag_rx_test;
  logic        sclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ws = 1'b1;
  logic        sd = 1'b0;
  logic [15:0] mag;
  logic        lv, rv;

  always #2.5 sclk = ~sclk;

  i2s_mag_rx uut (
    .sclk(sclk), .rst_n(rst_n), .ws(ws), .sd(sd),
    .mag_o(mag), .left_vld(lv), .right_vld(rv)
  );

  int checks = 0;
  int errors = 0;
  int unsigned cyc = 0;
  always @(posedge sclk) cyc <= cyc + 1;

  // Scoreboard queues, one entry per expected strobe.
  bit          q_ch[$];
  logic [15:0] q_mag[$];
  int unsigned q_cyc[$];
  string       q_tag[$];

  int          strobes = 0;
  int          stab_bad = 0;
  logic [15:0] last_mag = 16'h0;
  bit          prev_v = 1'b0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: one 32-bit half-frame; pushes the expected result first.
  task automatic send_slot(bit ch, logic [15:0] w, bit fill, string tag);
    logic [15:0] m;
    @(negedge sclk);
    ws = ch;
    sd = fill;
    if (w == 16'h8000)  m = 16'h7FFF;
    else if (w[15])     m = -w;
    else                m = w;
    q_ch.push_back(ch);
    q_mag.push_back(m);
    q_cyc.push_back(cyc + 18);
    q_tag.push_back(tag);
    for (int i = 0; i < 16; i++) begin
      @(negedge sclk);
      sd = w[15-i];
    end
    for (int i = 0; i < 15; i++) begin
      @(negedge sclk);
      sd = fill;
    end
  endtask

  // Monitor: compares every strobe against the scoreboard.
  always @(negedge sclk) begin
    if (rst_n) begin
      if (lv && rv) chk(1'b0, "R7", "both strobes high", 3, 1);
      if (lv || rv) begin
        strobes++;
        if (prev_v) chk(1'b0, "R6", "strobe wider than one cycle", 2, 1);
        if (q_ch.size() == 0) begin
          chk(1'b0, "R8", "unexpected strobe", int'(mag), 0);
        end else begin
          bit          ech;
          logic [15:0] em;
          int unsigned ec;
          string       et;
          ech = q_ch.pop_front();
          em  = q_mag.pop_front();
          ec  = q_cyc.pop_front();
          et  = q_tag.pop_front();
          chk(rv == ech, "R2", "channel of strobe", int'(rv), int'(ech));
          chk(mag == em, et, "magnitude", int'(mag), int'(em));
          chk(cyc == ec, "R6", "strobe cycle", int'(cyc), int'(ec));
        end
        last_mag = mag;
      end else if (mag != last_mag) begin
        stab_bad++;
      end
      prev_v = lv || rv;
    end
  end

  initial begin
    repeat (100000) @(posedge sclk);
    errors++;
    $display("FAIL R6 watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge sclk);
    chk(mag == 16'h0, "R1", "mag in reset", int'(mag), 0);
    chk(!lv && !rv, "R1", "strobes in reset", int'({lv, rv}), 0);
    @(negedge sclk);
    rst_n = 1'b1;
    @(negedge sclk);
    chk(mag == 16'h0 && !lv && !rv, "R1", "state after release", int'(mag), 0);

    // R8: half-frame already in progress at release, ws stays high.
    for (int i = 0; i < 12; i++) begin
      @(negedge sclk);
      sd = i[0];
    end
    repeat (20) @(negedge sclk);
    chk(strobes == 0, "R8", "strobes before first transition", strobes, 0);

    send_slot(1'b0, 16'h1234, 1'b1, "R4");
    send_slot(1'b1, 16'hEDCC, 1'b0, "R4");
    send_slot(1'b0, 16'h8000, 1'b1, "R5");
    send_slot(1'b1, 16'h7FFF, 1'b1, "R3");
    send_slot(1'b0, 16'h0000, 1'b1, "R3");
    send_slot(1'b1, 16'hFFFF, 1'b0, "R4");
    send_slot(1'b0, 16'h0001, 1'b0, "R3");
    send_slot(1'b1, 16'h8001, 1'b1, "R4");
    send_slot(1'b0, 16'hA5C3, 1'b0, "R3");

    repeat (40) @(negedge sclk);
    chk(q_ch.size() == 0, "R2", "pending expected strobes", q_ch.size(), 0);
    chk(strobes == 9, "R6", "strobe count", strobes, 9);
    chk(stab_bad == 0, "R6", "bus changes between strobes", stab_bad, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule